// File: doc/BRIEF.md
# Addressing-Mode Bus Cycle Sequencer

This block produces the clock-by-clock bus traffic of an 8-bit accumulator processor for three addressing cases: an absolute indexed read, an absolute indexed read-modify-write, and a jump through a pointer held in memory. A start pulse hands it an operation class, the address of the opcode, the two operand bytes, the index register value and a modify-operation select. The block then drives exactly one bus transaction per clock. It puts out the three instruction fetch cycles, any dummy cycle, the data cycles and, for read-modify-write, the write-back. It samples read data from the memory that the surrounding system provides.

When indexing carries into the high address byte, the extra cycle re-reads the last instruction byte rather than the half-formed address. A pointer whose low byte is all ones is incremented across the page boundary, at the cost of one cycle. A read-modify-write reads its target twice and writes only the final modified value. When the sequence ends, the block gives a one-cycle done pulse and holds the effective address or jump target.

Top module: `addr_cycle_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_act, bus_we and done are all low.
- R2: When start is seen high while idle, the next three clocks are read cycles at pc, pc+1 and pc+2, with the addition wrapping at 16 bits.
- R3: For class code 0 (code 3 behaves the same), the effective address is {op_hi, op_lo} + idx. With no carry out of the low byte, cycle 4 reads that address and the sequence has 4 cycles. With a carry, cycle 4 re-reads pc+2, cycle 5 reads the effective address, and the sequence has 5 cycles.
- R4: For class code 1 (read-modify-write), the effective address reads twice in consecutive cycles and a write to the same address follows. The sequence has 6 cycles without a carry. With a carry it has 7, and the extra cycle 4 re-reads pc+2.
- R5: The value written is the data captured in the second read, changed as mod_sel selects: 0 adds one, 1 subtracts one, 2 shifts left with zero fill, 3 shifts right with zero fill (all modulo 256).
- R6: bus_we is high only in the write cycle of a read-modify-write, and that cycle directly follows a read of the same address.
- R7: For class code 2 (indirect jump) with op_lo not equal to FF, cycle 4 reads the pointer {op_hi, op_lo} and cycle 5 reads the pointer plus one. The target is {data of cycle 5, data of cycle 4}, and the sequence has 5 cycles.
- R8: For class code 2 with op_lo equal to FF, cycle 4 reads the pointer, cycle 5 re-reads pc+2, and cycle 6 reads the pointer plus one, with the carry into the high byte (FFFF wraps to 0000). The sequence has 6 cycles.
- R9: done is high for exactly one clock, in the clock after the last bus cycle, with bus_act low. eff_addr then shows the effective address or jump target and holds it until the next done.
- R10: A start pulse while a sequence is running has no effect, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sequence (taken only when idle) |
| op_class | input | 2 | 0 indexed read, 1 indexed read-modify-write, 2 indirect jump, 3 as 0 |
| pc | input | 16 | Address of the opcode byte |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx | input | 8 | Index register value |
| mod_sel | input | 2 | Modify operation for read-modify-write |
| bus_addr | output | 16 | Bus address |
| bus_we | output | 1 | Write strobe, active high |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the cycle of its address |
| bus_act | output | 1 | High in every bus cycle of a sequence |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 16 | Effective address or jump target |

## Verification
A wrong state transition shows at the ports at once: an extra, missing or misplaced dummy cycle puts a wrong bus_addr or bus_we in that same clock, and each cycle of the trace is compared against the sequence worked out from the requirements. An error in the index carry or the pointer increment appears as a wrong address in the first data cycle, and the wrong eff_addr follows one clock after the last bus cycle. A bad modify operation or a value captured from the wrong read shows as wrong write data in the one write cycle. Wrong cycle counts push the done pulse off its expected clock, and the sequence that follows is then ignored as a busy start, so the trace goes out of step.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic [1:0] {
    CL_RD    = 2'd0,
    CL_RMW   = 2'd1,
    CL_JMP   = 2'd2,
    CL_RDALT = 2'd3
  } acs_class_e;

  typedef enum logic [1:0] {
    MD_INC = 2'd0,
    MD_DEC = 2'd1,
    MD_SHL = 2'd2,
    MD_SHR = 2'd3
  } acs_mod_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FOP,
    ST_FLO,
    ST_FHI,
    ST_DUMMY,
    ST_RD1,
    ST_RD2,
    ST_WR,
    ST_PLO,
    ST_PHI
  } acs_state_e;
endpackage

// File: rtl/acs_index_add.sv
module acs_index_add #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   base_lo,
  input  logic [DW-1:0]   base_hi,
  input  logic [DW-1:0]   offset,
  output logic [2*DW-1:0] eff,
  output logic            page_cross
);
  logic [DW:0] low_sum;

  always_comb begin
    low_sum    = {1'b0, base_lo} + {1'b0, offset};
    page_cross = low_sum[DW];
    eff        = {base_hi + {{(DW-1){1'b0}}, low_sum[DW]}, low_sum[DW-1:0]};
  end
endmodule

// File: rtl/acs_modify.sv
module acs_modify
  import acs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  input  acs_mod_e      sel,
  output logic [DW-1:0] dout
);
  always_comb begin
    case (sel)
      MD_INC:  dout = din + {{(DW-1){1'b0}}, 1'b1};
      MD_DEC:  dout = din - {{(DW-1){1'b0}}, 1'b1};
      MD_SHL:  dout = {din[DW-2:0], 1'b0};
      default: dout = {1'b0, din[DW-1:1]};
    endcase
  end
endmodule

// File: rtl/addr_cycle_seq.sv
module addr_cycle_seq
  import acs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op_class,
  input  logic [2*DW-1:0] pc,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   idx,
  input  logic [1:0]      mod_sel,
  output logic [2*DW-1:0] bus_addr,
  output logic            bus_we,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic            bus_act,
  output logic            done,
  output logic [2*DW-1:0] eff_addr
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  acs_state_e  st;
  acs_class_e  r_cls;
  acs_mod_e    r_mod;
  logic [AW-1:0] r_pc;
  logic [DW-1:0] r_lo, r_hi, r_idx;
  logic [DW-1:0] tgt_lo, mod_val, mod_out;
  logic [AW-1:0] ix_eff, ptr, ptr_next;
  logic          ix_cross;

  acs_index_add #(.DW(DW)) u_ix (
    .base_lo(r_lo), .base_hi(r_hi), .offset(r_idx),
    .eff(ix_eff), .page_cross(ix_cross)
  );

  acs_modify #(.DW(DW)) u_mod (
    .din(bus_rdata), .sel(r_mod), .dout(mod_out)
  );

  assign ptr      = {r_hi, r_lo};
  assign ptr_next = ptr + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      r_cls    <= CL_RD;
      r_mod    <= MD_INC;
      r_pc     <= '0;
      r_lo     <= '0;
      r_hi     <= '0;
      r_idx    <= '0;
      tgt_lo   <= '0;
      mod_val  <= '0;
      done     <= 1'b0;
      eff_addr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          r_cls <= acs_class_e'(op_class);
          r_mod <= acs_mod_e'(mod_sel);
          r_pc  <= pc;
          r_lo  <= op_lo;
          r_hi  <= op_hi;
          r_idx <= idx;
          st    <= ST_FOP;
        end
        ST_FOP: st <= ST_FLO;
        ST_FLO: st <= ST_FHI;
        ST_FHI: begin
          if (r_cls == CL_JMP) st <= ST_PLO;
          else if (ix_cross)   st <= ST_DUMMY;
          else                 st <= ST_RD1;
        end
        ST_DUMMY: st <= (r_cls == CL_JMP) ? ST_PHI : ST_RD1;
        ST_RD1: begin
          if (r_cls == CL_RMW) st <= ST_RD2;
          else begin
            st       <= ST_IDLE;
            done     <= 1'b1;
            eff_addr <= ix_eff;
          end
        end
        ST_RD2: begin
          mod_val <= mod_out;
          st      <= ST_WR;
        end
        ST_WR: begin
          st       <= ST_IDLE;
          done     <= 1'b1;
          eff_addr <= ix_eff;
        end
        ST_PLO: begin
          tgt_lo <= bus_rdata;
          st     <= (r_lo == ONES) ? ST_DUMMY : ST_PHI;
        end
        ST_PHI: begin
          st       <= ST_IDLE;
          done     <= 1'b1;
          eff_addr <= {bus_rdata, tgt_lo};
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_act   = (st != ST_IDLE);
    bus_we    = (st == ST_WR);
    bus_wdata = (st == ST_WR) ? mod_val : '0;
    case (st)
      ST_FLO:                 bus_addr = r_pc + ONE;
      ST_FHI, ST_DUMMY:       bus_addr = r_pc + TWO;
      ST_RD1, ST_RD2, ST_WR:  bus_addr = ix_eff;
      ST_PLO:                 bus_addr = ptr;
      ST_PHI:                 bus_addr = ptr_next;
      default:                bus_addr = r_pc;
    endcase
  end

  // R6
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> ($past(bus_act) && !$past(bus_we) && ($past(bus_addr) == bus_addr)));

  // R6
  no_idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !bus_we);

  // R2
  first_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_act && !$past(bus_act)) |-> (bus_addr == $past(pc)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_act && !bus_we));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_follows_bus_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_act));
endmodule

// File: tb/addr_cycle_seq_test.sv
`timescale 1ns/100ps
module addr_cycle_seq_test;
  typedef struct {
    bit          is_done;
    logic [15:0] a;
    logic        we;
    logic [7:0]  d;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op_class = 2'd0;
  logic [15:0] pc = 16'h0;
  logic [7:0]  op_lo = 8'h0, op_hi = 8'h0, idx = 8'h0;
  logic [1:0]  mod_sel = 2'd0;
  logic [15:0] bus_addr, eff_addr;
  logic        bus_we, bus_act, done;
  logic [7:0]  bus_wdata, bus_rdata;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
  endfunction

  function automatic logic [7:0] modf(input logic [7:0] v, input logic [1:0] s);
    case (s)
      2'd0: return v + 8'd1;
      2'd1: return v - 8'd1;
      2'd2: return {v[6:0], 1'b0};
      default: return {1'b0, v[7:1]};
    endcase
  endfunction

  assign bus_rdata = memf(bus_addr);

  addr_cycle_seq uut (
    .clk(clk), .rst(rst), .start(start), .op_class(op_class), .pc(pc),
    .op_lo(op_lo), .op_hi(op_hi), .idx(idx), .mod_sel(mod_sel),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_act(bus_act), .done(done), .eff_addr(eff_addr)
  );

  task automatic push(input bit dn, input logic [15:0] a, input logic w,
                      input logic [7:0] d, input string tag);
    exp_t e;
    e.is_done = dn; e.a = a; e.we = w; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per active or done cycle
  always @(negedge clk) begin
    if (!rst && !finished && (bus_act || done)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10", "unexpected activity", bus_addr, 16'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.is_done) begin
          chk(done && !bus_act, e.tag, "done slot", {14'h0, bus_act, done}, 16'h1);
          chk(eff_addr == e.a, e.tag, "eff_addr", eff_addr, e.a);
        end else begin
          chk(bus_act && !done, e.tag, "bus slot", {14'h0, bus_act, done}, 16'h2);
          chk(bus_addr == e.a, e.tag, "bus_addr", bus_addr, e.a);
          chk(bus_we == e.we, e.tag, "bus_we", {15'h0, bus_we}, {15'h0, e.we});
          if (e.we) chk(bus_wdata == e.d, e.tag, "bus_wdata", {8'h0, bus_wdata}, {8'h0, e.d});
        end
      end
    end
  end

  // Driver: called at a negedge, returns at the negedge of the done pulse
  task automatic run_op(input logic [1:0] c, input logic [15:0] p, input logic [7:0] lo,
                        input logic [7:0] hi, input logic [7:0] ix, input logic [1:0] m,
                        input bit poke);
    logic [8:0]  s;
    logic [15:0] ea, ptr, tgt;
    int n;
    string rt;
    push(0, p, 0, 0, "R2");
    push(0, p + 16'd1, 0, 0, "R2");
    push(0, p + 16'd2, 0, 0, "R2");
    if (c != 2'd2) begin
      s  = {1'b0, lo} + {1'b0, ix};
      ea = {hi + {7'h0, s[8]}, s[7:0]};
      rt = (c == 2'd1) ? "R4" : "R3";
      if (s[8]) push(0, p + 16'd2, 0, 0, rt);
      if (c == 2'd1) begin
        push(0, ea, 0, 0, "R4");
        push(0, ea, 0, 0, "R4");
        push(0, ea, 1, modf(memf(ea), m), "R5");
        n = 6 + int'(s[8]);
      end else begin
        push(0, ea, 0, 0, "R3");
        n = 4 + int'(s[8]);
      end
      push(1, ea, 0, 0, "R9");
    end else begin
      ptr = {hi, lo};
      push(0, ptr, 0, 0, "R7");
      if (lo == 8'hFF) push(0, p + 16'd2, 0, 0, "R8");
      push(0, ptr + 16'd1, 0, 0, (lo == 8'hFF) ? "R8" : "R7");
      tgt = {memf(ptr + 16'd1), memf(ptr)};
      n = (lo == 8'hFF) ? 6 : 5;
      push(1, tgt, 0, 0, (lo == 8'hFF) ? "R8" : "R7");
    end
    op_class = c; pc = p; op_lo = lo; op_hi = hi; idx = ix; mod_sel = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; op_class = 2'd2; pc = 16'h4321; op_lo = 8'hFF; op_hi = 8'h77;
      @(negedge clk);
      start = 1'b0;
      repeat (n - 2) @(negedge clk);
    end else begin
      repeat (n) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bus_act && !bus_we && !done, "R1", "outputs in reset",
        {13'h0, bus_act, bus_we, done}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_act && !bus_we && !done, "R1", "outputs after reset",
        {13'h0, bus_act, bus_we, done}, 16'h0);
    @(negedge clk);
    // R3 indexed read, no carry, carry, carry wrapping the page byte, code 3
    run_op(2'd0, 16'h0200, 8'h10, 8'h30, 8'h05, 2'd0, 0);
    run_op(2'd0, 16'h0300, 8'hF0, 8'h30, 8'h20, 2'd0, 0);
    run_op(2'd0, 16'hFFFE, 8'hFF, 8'hFF, 8'h01, 2'd0, 0);
    run_op(2'd3, 16'h0410, 8'h80, 8'h12, 8'h7F, 2'd0, 0);
    // R4 R5 read-modify-write with each modify code
    run_op(2'd1, 16'h0500, 8'h20, 8'h40, 8'h03, 2'd0, 0);
    run_op(2'd1, 16'h0510, 8'hC0, 8'h40, 8'h50, 2'd1, 0);
    run_op(2'd1, 16'h0520, 8'h01, 8'h22, 8'h00, 2'd2, 0);
    run_op(2'd1, 16'h0530, 8'hFE, 8'h22, 8'h02, 2'd3, 0);
    run_op(2'd1, 16'h0540, 8'hA5, 8'h55, 8'h5A, 2'd2, 0);
    // R7 R8 indirect jump
    run_op(2'd2, 16'h0600, 8'h34, 8'h12, 8'h00, 2'd0, 0);
    run_op(2'd2, 16'h0610, 8'hFF, 8'h12, 8'h00, 2'd0, 0);
    run_op(2'd2, 16'h0620, 8'hFF, 8'hFF, 8'h00, 2'd0, 0);
    run_op(2'd2, 16'h0630, 8'hFE, 8'hFF, 8'h00, 2'd0, 0);
    // R10 start pulses while busy
    run_op(2'd1, 16'h0700, 8'hF8, 8'h10, 8'h10, 2'd0, 1);
    run_op(2'd0, 16'h0710, 8'h02, 8'h10, 8'h01, 2'd0, 1);
    repeat (3) @(negedge clk);
    // R9 eff_addr holds after done, every expected item consumed
    chk(eff_addr == 16'h1003, "R9", "eff_addr held", eff_addr, 16'h1003);
    chk(q.size() == 0, "R9", "expected items left", 16'(q.size()), 16'h0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule